// File: doc/BRIEF.md
# Event Counter Bank with Sticky Overflow and Freeze

This block holds a bank of event counters that share one status register. Each counter adds one for every cycle its event input is high. When a counter passes from all ones to zero it wraps, and its overflow flag in the status register is set. The flag stays set until software writes it. An overflow from a counter whose interrupt enable is high also sets the freeze bit. The freeze bit stops every counter in the bank until software clears it.

The freeze level is also driven on an output. Sampling logic nearby can use it to know that its captured data is stable and can be read. The same level drives the interrupt request line. Software has three paths into the block: it reads the status word, it overwrites the status word in a single write, and it can preload any counter. The preload lets a counter start close to the wrap point. All pins are plain level or pulse signals. Nothing in the block uses a handshake, so no input is ever held off.

Top module: `perf_freeze_status`

## Requirements
- R1: After reset every counter reads 0, and the whole 64-bit status word reads 0.
- R2: While the freeze bit (status bit 0) is 0, a counter whose event bit is 1 in a cycle increases by exactly one at that clock edge. A counter whose event bit is 0 holds its value.
- R3: A counter at 32'hFFFF_FFFF that takes an event wraps to 0. This sets status bit 4+n for counter n, one cycle after the event. The bit stays at 1 until a status write changes it.
- R4: An overflow of a counter whose interrupt enable bit is 0 sets that counter's flag and leaves the freeze bit unchanged.
- R5: An overflow of a counter whose interrupt enable bit is 1 sets the freeze bit at the same edge as the flag. The freeze bit stays at 1 until a status write clears it.
- R6: While the freeze bit is 1, no counter changes on events.
- R7: A status write replaces the freeze bit with data bit 0 and the flags with data bits 7..4. Status bits 3..1 and 63..8 always read 0, whatever value is written to them.
- R8: An overflow in the same cycle as a status write wins. The counter's flag ends at 1, and the freeze bit ends at 1 if that counter's enable is 1, even when the written data has those bits at 0.
- R9: A counter write loads the counter selected by cnt_wr_sel with cnt_wr_data. The load takes priority over an event to that counter in the same cycle, and a load never counts as an overflow.
- R10: irq_o and frozen_o both equal status bit 0 in every cycle.
- R11: Several counters may overflow in the same cycle, and each one sets its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_CNT | One event pulse bit per counter |
| oi_en_i | input | NUM_CNT | Interrupt enable for each counter's overflow |
| cnt_wr_en | input | 1 | Counter preload strobe |
| cnt_wr_sel | input | IDX_W | Index of the counter to preload |
| cnt_wr_data | input | CNT_W | Preload value |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 64 | Status write data |
| stat_rd_data | output | 64 | Status word: bit 0 is freeze, bits 4+n are flags, all other bits read 0 |
| cnt_value | output | NUM_CNT*CNT_W | All counter values, counter n at bits n*CNT_W upward |
| frozen_o | output | 1 | Freeze level, for capture logic |
| irq_o | output | 1 | Interrupt request level |

## Verification
The assertions rely on two input conditions. Counters change only through events or preloads. The freeze bit can rise without a status write only when some counter overflows while its enable is high, so the enable seen in that cycle is the one that explains the rise. The stimulus applies every input change just after a clock edge and holds it for one full cycle. Preloads often place counters within a few counts of the wrap point, so overflows happen regularly. Status writes are sparse and use random data, so clears, forced sets and writes that collide with an overflow all occur.

// File: rtl/perf_freeze_pkg.sv
package perf_freeze_pkg;
  // Status word layout; neighbours decode these positions.
  localparam int STAT_W   = 64;
  localparam int FRZ_BIT  = 0;
  localparam int FLAG_LSB = 4;
endpackage

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  // A wrap happens only on a real increment from all ones.
  assign ovf = inc && !load && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/perf_ovf_status.sv
module perf_ovf_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ovf,
  input  logic [N-1:0] oi_en,
  input  logic         wr,
  input  logic         wr_frz,
  input  logic [N-1:0] wr_flags,
  output logic         frz,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_base;
  logic         frz_base;

  // The write goes in first; a new overflow is ORed on top so it wins.
  assign flags_base = wr ? wr_flags : flags;
  assign frz_base   = wr ? wr_frz   : frz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      frz   <= 1'b0;
    end else begin
      flags <= flags_base | ovf;
      frz   <= frz_base | (|(ovf & oi_en));
    end
  end
endmodule

// File: rtl/perf_freeze_status.sv
module perf_freeze_status
  import perf_freeze_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       evt_i,
  input  logic [NUM_CNT-1:0]       oi_en_i,
  input  logic                     cnt_wr_en,
  input  logic [IDX_W-1:0]         cnt_wr_sel,
  input  logic [CNT_W-1:0]         cnt_wr_data,
  input  logic                     stat_wr_en,
  input  logic [STAT_W-1:0]        stat_wr_data,
  output logic [STAT_W-1:0]        stat_rd_data,
  output logic [NUM_CNT*CNT_W-1:0] cnt_value,
  output logic                     frozen_o,
  output logic                     irq_o
);
  logic [NUM_CNT-1:0] ovf;
  logic [NUM_CNT-1:0] flags;
  logic               frz;

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic ld;
    assign ld = cnt_wr_en && (cnt_wr_sel == IDX_W'(n));
    perf_event_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (cnt_wr_data),
      .inc      (evt_i[n] && !frz),
      .cnt      (cnt_value[n*CNT_W +: CNT_W]),
      .ovf      (ovf[n])
    );
  end

  perf_ovf_status #(.N(NUM_CNT)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf      (ovf),
    .oi_en    (oi_en_i),
    .wr       (stat_wr_en),
    .wr_frz   (stat_wr_data[FRZ_BIT]),
    .wr_flags (stat_wr_data[FLAG_LSB +: NUM_CNT]),
    .frz      (frz),
    .flags    (flags)
  );

  always_comb begin
    stat_rd_data                       = '0;
    stat_rd_data[FRZ_BIT]              = frz;
    stat_rd_data[FLAG_LSB +: NUM_CNT]  = flags;
  end

  assign frozen_o = frz;
  assign irq_o    = frz;
endmodule

// File: rtl/perf_freeze_status_chk.sv
module perf_freeze_status_chk #(
  parameter int N = 4,
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_wr_en,
  input logic         stat_wr_en,
  input logic [N-1:0] oi_en_i,
  input logic [63:0]  stat_rd_data,
  input logic [N*W-1:0] cnt_value,
  input logic         frozen_o,
  input logic         irq_o
);
  // R6: counters hold while frozen unless software preloads one
  p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_o && !cnt_wr_en |=> $stable(cnt_value));

  // R3: flags never drop without a status write
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_en |=> (($past(stat_rd_data[4 +: N]) & ~stat_rd_data[4 +: N]) == '0));

  // R5: freeze persists until software writes status
  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_o && !stat_wr_en |=> frozen_o);

  // R4: freeze rising without a write needs an enabled counter's flag
  p_freeze_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr_en) && $rose(frozen_o) |-> (($past(oi_en_i) & stat_rd_data[4 +: N]) != '0));

  // R7: reserved status bits are zero
  p_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_data[3:1] == 3'b0) && (stat_rd_data[63:4+N] == '0));

  // R10: request and freeze outputs follow status bit 0
  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == stat_rd_data[0]) && (frozen_o == stat_rd_data[0]));
endmodule

bind perf_freeze_status perf_freeze_status_chk #(.N(NUM_CNT), .W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_wr_en    (cnt_wr_en),
  .stat_wr_en   (stat_wr_en),
  .oi_en_i      (oi_en_i),
  .stat_rd_data (stat_rd_data),
  .cnt_value    (cnt_value),
  .frozen_o     (frozen_o),
  .irq_o        (irq_o)
);

// File: tb/tb_perf_freeze_status.sv
`timescale 1ns/1ps
module tb_perf_freeze_status;
  localparam int N = 4;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic [N-1:0]  oi_en_i = '0;
  logic          cnt_wr_en = 1'b0;
  logic [1:0]    cnt_wr_sel = '0;
  logic [W-1:0]  cnt_wr_data = '0;
  logic          stat_wr_en = 1'b0;
  logic [63:0]   stat_wr_data = '0;
  logic [63:0]   stat_rd_data;
  logic [N*W-1:0] cnt_value;
  logic          frozen_o, irq_o;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_cnt [N];
  logic [N-1:0] m_flag;
  logic         m_fr;

  always #2.5 clk = ~clk;

  perf_freeze_status dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .oi_en_i(oi_en_i),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel), .cnt_wr_data(cnt_wr_data),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .stat_rd_data(stat_rd_data), .cnt_value(cnt_value),
    .frozen_o(frozen_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_stat();
    logic [63:0] s = '0;
    s[0] = m_fr;
    s[4 +: N] = m_flag;
    return s;
  endfunction

  // Model step built from R2, R3, R4, R5, R6, R7, R8, R9
  task automatic model_step();
    logic [N-1:0] ov = '0;
    for (int n = 0; n < N; n++) begin
      if (cnt_wr_en && cnt_wr_sel == 2'(n)) m_cnt[n] = cnt_wr_data;
      else if (evt_i[n] && !m_fr) begin
        if (m_cnt[n] == '1) ov[n] = 1'b1;
        m_cnt[n] = m_cnt[n] + 1;
      end
    end
    m_flag = (stat_wr_en ? stat_wr_data[7:4] : m_flag) | ov;
    m_fr   = (stat_wr_en ? stat_wr_data[0] : m_fr) | (|(ov & oi_en_i));
  endtask

  task automatic check_all(input string tag);
    for (int n = 0; n < N; n++) chk(64'(cnt_value[n*W +: W]), 64'(m_cnt[n]), {tag, " cnt R2"});
    chk(stat_rd_data, exp_stat(), {tag, " status R7"});
    chk({62'b0, irq_o, frozen_o}, {62'b0, m_fr, m_fr}, {tag, " irq R10"});
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_step();
    #1;
    check_all(tag);
    evt_i = '0; cnt_wr_en = 1'b0; stat_wr_en = 1'b0;
  endtask

  task automatic preload(input int idx, input logic [W-1:0] v);
    cnt_wr_en = 1'b1; cnt_wr_sel = 2'(idx); cnt_wr_data = v;
    step("R9 preload");
  endtask

  task automatic swrite(input logic [63:0] d, input string tag);
    stat_wr_en = 1'b1; stat_wr_data = d;
    step(tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int n = 0; n < N; n++) m_cnt[n] = '0;
    m_flag = '0; m_fr = 1'b0;
    #12 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(stat_rd_data, 64'd0, "R1 status");
    chk(64'(cnt_value), 64'd0, "R1 counters low");
    @(negedge clk);

    // R2 plain counting
    evt_i = 4'b1011; step("R2");
    evt_i = 4'b1111; step("R2");

    // R4 overflow without enable: flag only
    preload(1, 32'hFFFF_FFFF);
    oi_en_i = 4'b0000; evt_i = 4'b0010; step("R4");
    chk(stat_rd_data, 64'h20, "R4 flag without freeze");
    chk(64'(cnt_value[W +: W]), 64'd0, "R3 wrap to zero");

    // R5 enabled overflow freezes; R6 counters hold
    preload(2, 32'hFFFF_FFFF);
    oi_en_i = 4'b0100; evt_i = 4'b0100; step("R5");
    chk(stat_rd_data, 64'h61, "R5 freeze set");
    chk({63'b0, irq_o}, 64'd1, "R10 irq high");
    evt_i = 4'b1111; step("R6");
    chk(64'(cnt_value[0 +: W]), 64'd2, "R6 counter 0 held");

    // R7 write with reserved bits set; freeze cleared, flags rewritten
    swrite(64'hFFFF_FFFF_FFFF_FF8E, "R7");
    chk(stat_rd_data, 64'h80, "R7 reserved bits read zero");

    // R8 overflow beats clearing write
    oi_en_i = 4'b0001;
    preload(0, 32'hFFFF_FFFF);
    evt_i = 4'b0001;
    swrite(64'h0, "R8");
    chk(stat_rd_data, 64'h11, "R8 overflow wins over write");
    swrite(64'h0, "R7 clear");

    // R9 load beats event
    cnt_wr_en = 1'b1; cnt_wr_sel = 2'd3; cnt_wr_data = 32'hFFFF_FFFF;
    evt_i = 4'b1000; oi_en_i = 4'b1000; step("R9");
    chk(64'(cnt_value[3*W +: W]), 64'hFFFF_FFFF, "R9 load priority");
    chk(stat_rd_data, 64'h0, "R9 load is not overflow");

    // R11 simultaneous overflows
    oi_en_i = 4'b0000;
    for (int n = 0; n < N; n++) preload(n, 32'hFFFF_FFFF);
    evt_i = 4'b1111; step("R11");
    chk(stat_rd_data, 64'hF0, "R11 all flags");
    swrite(64'h0, "R7 clear");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      evt_i   = 4'($urandom);
      if ($urandom % 8 == 0) oi_en_i = 4'($urandom);
      if ($urandom % 10 == 0) begin
        cnt_wr_en = 1'b1; cnt_wr_sel = 2'($urandom);
        cnt_wr_data = ($urandom % 2) ? 32'hFFFF_FFFF - ($urandom % 3) : $urandom;
      end
      if ($urandom % 24 == 0) begin
        stat_wr_en = 1'b1;
        stat_wr_data = {$urandom, $urandom};
      end
      step("random R3 R5 R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule